// File: doc/BRIEF.md
# Session Seed Entropy Capture Unit

This unit hands out a fresh 32-bit seed each time a cryptographic session is opened. A small counter runs freely on an asynchronous fast clock, standing in for an on-die oscillator. After reset, the reference clock times a fixed window of `WINDOW` cycles. When that window closes, the fast counter is told to stop. Its frozen value is brought across to the reference clock through a two-flop request/acknowledge exchange. That capture happens exactly once per reset.

The captured count never appears on the output directly. It loads a 32-bit Galois pseudo-noise register, and that register steps once for every seed the unit issues. Each seed combines three values: the next pseudo-noise word, the latest externally supplied seed, and the seed issued just before it. Feeding the same external seed in again therefore still gives a different result. A session request that arrives before the capture has finished is held and served once the capture completes.

Top module: `session_seed_unit`

## Requirements
- R1: While reset is applied, `seed_vld` is 0 and `seed_out` is 0, and the retained previous seed is cleared to 0.
- R2: The fast counter is sampled exactly once per reset. The freeze request is raised only after `WINDOW` reference cycles have elapsed. The counter holds its value once frozen, and all later seeds derive from that one capture.
- R3: The pseudo-noise register is loaded with the zero-extended captured count. A zero count is replaced by 32'h6A09E667. Each step shifts right, and when the bit shifted out is 1 the mask 32'h80200003 is XORed in.
- R4: An issued seed equals the stepped pseudo-noise word XOR the external seed in use XOR the previously issued seed (0 for the first seed after reset).
- R5: Once the capture is complete, a request sampled on a clock edge drives `seed_vld` high for exactly that following cycle, with `seed_out` valid. `seed_out` holds its value between issues.
- R6: A request made before the capture completes is held pending. It is served as one issued seed as soon as the pseudo-noise register is loaded.
- R7: A strobe on `ext_seed_vld` latches `ext_seed` without issuing a seed. When the strobe and a request fall in the same cycle, the new value is used for that seed.
- R8: Issuing a seed again with the same external seed gives an output different from the previous one.
- R9: The pseudo-noise register advances exactly one step per issued seed, including on back-to-back requests.
- R10: Several requests that arrive while a request is already pending produce one seed, not several.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference (crystal) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| clk_fast | input | 1 | Asynchronous fast clock driving the jitter counter |
| ext_seed | input | 32 | Externally acquired seed value |
| ext_seed_vld | input | 1 | Strobe that latches `ext_seed` |
| session_req | input | 1 | Request for a new session seed |
| seed_out | output | 32 | Issued session seed |
| seed_vld | output | 1 | One-cycle flag marking a newly issued seed |

## Verification
Two pairs of functions can meet in the same cycle. An external-seed strobe can coincide with a session request. A request can also be pending just as the pseudo-noise register becomes ready. The bench drives the strobe and the request together and requires the seed to use the new external value. It also opens each reset with requests raised during the capture window and requires exactly one seed once the window closes. The bench recovers the captured count from the first seed by searching the small counter range for the matching pseudo-noise step, then predicts every later seed arithmetically. It sweeps the fast-clock period across resets, so the zero-count substitution is also reached.

// File: rtl/seed_pkg.sv
`timescale 1ns/1ps
package seed_pkg;
  localparam int unsigned PN_W = 32;
  localparam logic [PN_W-1:0] PN_TAPS     = 32'h8020_0003;
  localparam logic [PN_W-1:0] PN_ZERO_SUB = 32'h6A09_E667;

  typedef enum logic [1:0] {
    CAP_WINDOW = 2'd0,
    CAP_REQ    = 2'd1,
    CAP_DONE   = 2'd2
  } cap_state_t;

  function automatic logic [PN_W-1:0] pn_step(input logic [PN_W-1:0] s);
    logic [PN_W-1:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ PN_TAPS;
    return r;
  endfunction
endpackage

// File: rtl/ssu_rst_sync.sv
`timescale 1ns/1ps
module ssu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/ssu_jitter_ctr.sv
`timescale 1ns/1ps
module ssu_jitter_ctr #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_fast,
  input  logic             rst_fast_n,
  input  logic             freeze_req,
  output logic [CNT_W-1:0] cnt,
  output logic             frozen_ack
);
  logic [SYNC_STAGES-1:0] req_sh_q;
  logic                   req_s;
  logic [CNT_W-1:0]       cnt_q, cnt_nxt;
  logic                   ack_q, ack_nxt;

  assign req_s = req_sh_q[SYNC_STAGES-1];

  always_comb begin
    cnt_nxt = req_s ? cnt_q : cnt_q + CNT_W'(1);
    ack_nxt = req_s;
  end

  always_ff @(posedge clk_fast or negedge rst_fast_n) begin
    if (!rst_fast_n) begin
      req_sh_q <= '0;
      cnt_q    <= '0;
      ack_q    <= 1'b0;
    end else begin
      req_sh_q <= {req_sh_q[SYNC_STAGES-2:0], freeze_req};
      cnt_q    <= cnt_nxt;
      ack_q    <= ack_nxt;
    end
  end

  assign cnt        = cnt_q;
  assign frozen_ack = ack_q;

  // R2: once acknowledged, the count stays frozen
  a_r2_frozen_hold: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    frozen_ack |=> $stable(cnt));
  a_r2_ack_sticky: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    frozen_ack |=> frozen_ack);
endmodule

// File: rtl/ssu_capture.sv
`timescale 1ns/1ps
module ssu_capture
  import seed_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned WINDOW      = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_ref_n,
  input  logic [CNT_W-1:0] fast_cnt,
  input  logic             fast_ack,
  output logic             freeze_req,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_load
);
  localparam int unsigned WIN_W = $clog2(WINDOW + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);

  cap_state_t             st_q, st_nxt;
  logic [WIN_W-1:0]       win_q, win_nxt;
  logic [SYNC_STAGES-1:0] ack_sh_q;
  logic                   ack_s;
  logic [CNT_W-1:0]       val_q, val_nxt;
  logic                   load_q, load_nxt;

  assign ack_s = ack_sh_q[SYNC_STAGES-1];

  always_comb begin
    st_nxt   = st_q;
    win_nxt  = win_q;
    val_nxt  = val_q;
    load_nxt = 1'b0;
    unique case (st_q)
      CAP_WINDOW: begin
        if (win_q == WIN_LAST) st_nxt = CAP_REQ;
        else                   win_nxt = win_q + WIN_W'(1);
      end
      CAP_REQ: begin
        if (ack_s) begin
          st_nxt   = CAP_DONE;
          val_nxt  = fast_cnt;
          load_nxt = 1'b1;
        end
      end
      default: st_nxt = CAP_DONE;
    endcase
  end

  always_ff @(posedge clk_ref or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      st_q     <= CAP_WINDOW;
      win_q    <= '0;
      ack_sh_q <= '0;
      val_q    <= '0;
      load_q   <= 1'b0;
    end else begin
      st_q     <= st_nxt;
      win_q    <= win_nxt;
      ack_sh_q <= {ack_sh_q[SYNC_STAGES-2:0], fast_ack};
      val_q    <= val_nxt;
      load_q   <= load_nxt;
    end
  end

  assign freeze_req = (st_q != CAP_WINDOW);
  assign cap_val    = val_q;
  assign cap_load   = load_q;

  // R2: capture happens once and only after the full window
  a_r2_load_once: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    cap_load |=> !cap_load && (st_q == CAP_DONE));
  a_r2_done_sticky: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    (st_q == CAP_DONE) |=> (st_q == CAP_DONE) && !cap_load);
  a_r2_window_spent: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    freeze_req |-> (win_q == WIN_LAST));
endmodule

// File: rtl/ssu_pn_gen.sv
`timescale 1ns/1ps
module ssu_pn_gen
  import seed_pkg::*;
(
  input  logic            clk_ref,
  input  logic            rst_ref_n,
  input  logic            load,
  input  logic [PN_W-1:0] seed_in,
  input  logic            adv,
  output logic [PN_W-1:0] state,
  output logic            ready
);
  logic [PN_W-1:0] st_q, st_nxt;
  logic            rdy_q, rdy_nxt;

  always_comb begin
    st_nxt  = st_q;
    rdy_nxt = rdy_q;
    if (load) begin
      st_nxt  = (seed_in == '0) ? PN_ZERO_SUB : seed_in;
      rdy_nxt = 1'b1;
    end else if (adv && rdy_q) begin
      st_nxt = pn_step(st_q);
    end
  end

  always_ff @(posedge clk_ref or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      st_q  <= '0;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      rdy_q <= rdy_nxt;
    end
  end

  assign state = st_q;
  assign ready = rdy_q;

  // R3: a loaded generator never holds the all-zero lockup state
  a_r3_nonzero: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    ready |-> (state != '0));
  // R9: without an issue the generator does not move
  a_r9_hold: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    (ready && !adv && !load) |=> $stable(state));
endmodule

// File: rtl/ssu_mixer.sv
`timescale 1ns/1ps
module ssu_mixer
  import seed_pkg::*;
(
  input  logic            clk_ref,
  input  logic            rst_ref_n,
  input  logic [PN_W-1:0] ext_seed,
  input  logic            ext_vld,
  input  logic            req,
  input  logic            pn_ready,
  input  logic [PN_W-1:0] pn_state,
  output logic            pn_adv,
  output logic [PN_W-1:0] seed_out,
  output logic            seed_vld
);
  logic [PN_W-1:0] ext_q, ext_nxt, ext_use;
  logic [PN_W-1:0] prev_q, prev_nxt;
  logic [PN_W-1:0] out_q, out_nxt, mix;
  logic            pend_q, pend_nxt;
  logic            vld_q, issue;

  always_comb begin
    ext_use  = ext_vld ? ext_seed : ext_q;
    issue    = pn_ready && (req || pend_q);
    mix      = pn_step(pn_state) ^ ext_use ^ prev_q;
    ext_nxt  = ext_use;
    pend_nxt = (pend_q || req) && !issue;
    prev_nxt = issue ? mix : prev_q;
    out_nxt  = issue ? mix : out_q;
  end

  always_ff @(posedge clk_ref or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      ext_q  <= '0;
      prev_q <= '0;
      out_q  <= '0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      ext_q  <= ext_nxt;
      prev_q <= prev_nxt;
      out_q  <= out_nxt;
      pend_q <= pend_nxt;
      vld_q  <= issue;
    end
  end

  assign pn_adv   = issue;
  assign seed_out = out_q;
  assign seed_vld = vld_q;

  // R5: no seed before the generator is loaded
  a_r5_vld_needs_ready: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    seed_vld |-> pn_ready);
  // R6: a pending request is served as soon as the generator is ready
  a_r6_pending_served: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    (pend_q && pn_ready) |=> seed_vld);
  // R10: every seed is backed by a request
  a_r10_no_spurious: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    seed_vld |-> $past(req || pend_q));
  // R4: retained value follows the issued seed
  a_r4_prev_tracks: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    seed_vld |-> (prev_q == seed_out));
  // R7: a strobe latches the external seed
  a_r7_ext_latch: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    ext_vld |=> (ext_q == $past(ext_seed)));
endmodule

// File: rtl/session_seed_unit.sv
`timescale 1ns/1ps
module session_seed_unit
  import seed_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned WINDOW      = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_ref,
  input  logic        rst_n,
  input  logic        clk_fast,
  input  logic [31:0] ext_seed,
  input  logic        ext_seed_vld,
  input  logic        session_req,
  output logic [31:0] seed_out,
  output logic        seed_vld
);
  logic             rst_ref_n, rst_fast_n;
  logic             freeze_req, frozen_ack;
  logic [CNT_W-1:0] fast_cnt, cap_val;
  logic             cap_load;
  logic [PN_W-1:0]  pn_state;
  logic             pn_ready, pn_adv;

  ssu_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_ref (
    .clk(clk_ref), .arst_n(rst_n), .srst_n(rst_ref_n));

  ssu_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_fast (
    .clk(clk_fast), .arst_n(rst_n), .srst_n(rst_fast_n));

  ssu_jitter_ctr #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_jitter (
    .clk_fast(clk_fast), .rst_fast_n(rst_fast_n), .freeze_req(freeze_req),
    .cnt(fast_cnt), .frozen_ack(frozen_ack));

  ssu_capture #(.CNT_W(CNT_W), .WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES)) i_capture (
    .clk_ref(clk_ref), .rst_ref_n(rst_ref_n), .fast_cnt(fast_cnt),
    .fast_ack(frozen_ack), .freeze_req(freeze_req), .cap_val(cap_val),
    .cap_load(cap_load));

  ssu_pn_gen i_pn (
    .clk_ref(clk_ref), .rst_ref_n(rst_ref_n), .load(cap_load),
    .seed_in(PN_W'(cap_val)), .adv(pn_adv), .state(pn_state), .ready(pn_ready));

  ssu_mixer i_mix (
    .clk_ref(clk_ref), .rst_ref_n(rst_ref_n), .ext_seed(ext_seed),
    .ext_vld(ext_seed_vld), .req(session_req), .pn_ready(pn_ready),
    .pn_state(pn_state), .pn_adv(pn_adv), .seed_out(seed_out),
    .seed_vld(seed_vld));

  // R1: outputs quiet while reset holds
  a_r1_reset_quiet: assert property (@(posedge clk_ref)
    !rst_ref_n |-> (!seed_vld && seed_out == '0));
endmodule

// File: tb/test_session_seed_unit.sv
`timescale 1ns/1ps
module test_session_seed_unit;
  localparam real TCLK = 10.0;
  localparam int  CNT_W = 2;
  localparam int  WINDOW = 40;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam logic [31:0] ZSUB = 32'h6A09_E667;

  logic        clk_ref = 1'b0, clk_fast = 1'b0, rst_n = 1'b0;
  logic [31:0] ext_seed = '0;
  logic        ext_seed_vld = 1'b0, session_req = 1'b0;
  logic [31:0] seed_out;
  logic        seed_vld;
  real         fast_half = 10.0;

  int checks = 0, fails = 0, zero_hits = 0;
  bit finished = 0;

  session_seed_unit #(.CNT_W(CNT_W), .WINDOW(WINDOW), .SYNC_STAGES(2)) i_session_seed_unit (
    .clk_ref(clk_ref), .rst_n(rst_n), .clk_fast(clk_fast), .ext_seed(ext_seed),
    .ext_seed_vld(ext_seed_vld), .session_req(session_req),
    .seed_out(seed_out), .seed_vld(seed_vld));

  always #(TCLK/2) clk_ref = ~clk_ref;
  initial forever #(fast_half) clk_fast = ~clk_fast;

  function automatic logic [31:0] step(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_ref);
  endtask

  logic [31:0] pn, prev, ext_cur, exp_v;

  task automatic issue_check(input string rq);
    session_req = 1'b1;
    tick();
    session_req = 1'b0;
    ext_seed_vld = 1'b0;
    pn    = step(pn);
    exp_v = pn ^ ext_cur ^ prev;
    chk(seed_vld == 1'b1, rq, {31'b0, seed_vld}, 32'd1);
    chk(seed_out == exp_v, rq, seed_out, exp_v);
    prev = exp_v;
  endtask

  initial begin
    for (int t = 0; t < 11; t++) begin
      int pulses, first_cyc, cyc;
      logic [31:0] out1, p1, e1;
      bit found, zhit;
      rst_n = 1'b0;
      session_req = 1'b0;
      ext_seed_vld = 1'b0;
      fast_half = 10.0 + 0.5 * t;
      repeat (4) tick();
      // R1: reset state
      chk(seed_vld == 1'b0, "R1", {31'b0, seed_vld}, 32'd0);
      chk(seed_out == 32'd0, "R1", seed_out, 32'd0);
      rst_n = 1'b1;
      repeat (3) tick();
      // R6/R10: two requests during the window, one with an external seed (R7)
      e1 = 32'h1234_5678 ^ (t * 32'h0101_0101);
      ext_seed = e1; ext_seed_vld = 1'b1; session_req = 1'b1;
      tick();
      ext_seed_vld = 1'b0;
      tick();
      session_req = 1'b0;
      pulses = 0; first_cyc = -1; out1 = '0;
      for (cyc = 2; cyc < WINDOW + 80; cyc++) begin
        tick();
        if (seed_vld) begin
          pulses++;
          if (first_cyc < 0) begin first_cyc = cyc; out1 = seed_out; end
        end
      end
      chk(pulses == 1, "R10", pulses, 32'd1);
      chk(first_cyc >= WINDOW, "R2", first_cyc, WINDOW);
      // R3: recover captured count from first seed (prev=0, R4)
      p1 = out1 ^ e1;
      found = 0; zhit = 0;
      for (int s = 0; s < (1 << CNT_W); s++) begin
        logic [31:0] ld;
        ld = (s == 0) ? ZSUB : 32'(s);
        if (step(ld) == p1) begin found = 1; if (s == 0) zhit = 1; end
      end
      chk(found, "R3", p1, 32'h0);
      if (zhit) zero_hits++;
      pn = p1; prev = out1; ext_cur = e1;
      // R8: replay of the same external seed (R2 chain continues from one capture)
      issue_check("R8");
      chk(seed_out != out1, "R8", seed_out, out1);
      tick();
      chk(seed_vld == 1'b0, "R5", {31'b0, seed_vld}, 32'd0);
      // R7: strobe and request in the same cycle
      ext_seed = 32'hCAFE_0000 + t; ext_seed_vld = 1'b1; ext_cur = ext_seed;
      issue_check("R7");
      // R7: strobe alone issues nothing, used by the next request
      ext_seed = 32'h0BAD_F00D ^ t; ext_seed_vld = 1'b1; ext_cur = ext_seed;
      tick();
      ext_seed_vld = 1'b0;
      ext_seed = 32'hFFFF_FFFF;
      chk(seed_vld == 1'b0, "R7", {31'b0, seed_vld}, 32'd0);
      chk(seed_out == prev, "R5", seed_out, prev);
      issue_check("R7");
      // R9: back-to-back requests each step the generator once
      issue_check("R9");
      issue_check("R9");
      repeat (3) tick();
      chk(seed_vld == 1'b0, "R5", {31'b0, seed_vld}, 32'd0);
      chk(seed_out == prev, "R5", seed_out, prev);
    end
    // R3: the zero-count substitution was reached in the sweep
    chk(zero_hits > 0, "R3", zero_hits, 32'd1);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule